// File: doc/BRIEF.md
# Prioritized Trap and Interrupt Arbiter

At each instruction boundary this block decides which pending event a simple processor core takes. The candidates are a non-maskable interrupt, three maskable interrupt classes (external, software, timer), and a synchronous exception raised by the instruction that is retiring. The block reports its choice in the same cycle on a take strobe, a 4-bit cause code and an interrupt flag. The core then redirects its fetch.

The arbiter keeps the global interrupt enable, the priority level of the handler that is running, and a latch that blocks a second non-maskable interrupt. Taking any event clears the global enable and pushes the prior enable and level onto a small internal context stack. A return-from-handler strobe pops that stack and releases the non-maskable latch. Nesting works when software sets the enable again inside a handler. After that, only a class whose priority is strictly above the running level, and strictly above a software threshold, can preempt the handler.

If an interrupt wins over an exception at the same boundary, the exception is discarded and no pending state is kept for it. The core fetches the faulting instruction again after the handler, and that instruction raises the exception again.

Top module: `trap_arbiter`

## Requirements
- R1: At one boundary the event taken follows this order: non-maskable interrupt (code 15), external (code 11), software (code 3), timer (code 7), then the synchronous exception. `is_irq_o` is 1 for the four interrupts. For the exception it is 0, and `cause_o` equals `exc_code_i`. In `pend_i` and `mask_i`, bit 2 is external, bit 1 is software and bit 0 is timer.
- R2: An exception that loses to an interrupt is not stored. After the return, a boundary with no exception request and no pending interrupt produces no take.
- R3: A maskable class is delivered only when its `pend_i` bit is set, its `mask_i` bit is set and `ie_o` is 1. The exception is taken whatever the value of `ie_o`. `ie_set_i` sets `ie_o` and `ie_clr_i` clears it, both on the next edge.
- R4: Class priorities are external=3, software=2 and timer=1. A class is delivered only when its priority is greater than `level_o`. A class held back this way is delivered after the return that lowers `level_o`. Taking a maskable class sets `level_o` to that class's priority.
- R5: When software has set `ie_o` again inside a handler, a class of higher priority preempts that handler.
- R6: A maskable class is delivered only when its priority is greater than `thresh_i`. The threshold is an input that the block never changes.
- R7: The non-maskable interrupt ignores `ie_o`. Once one is taken, `nmi_busy_o` is 1 and further non-maskable requests are not taken until any `ret_i`, including a return from an exception handler nested inside it.
- R8: Every take clears `ie_o` on the next edge and pushes {ie, level} onto a 4-deep stack. Each `ret_i` pops the stack and restores `ie_o` and `level_o`.
- R9: `take_o` is 1 only in a cycle with `boundary_i` high and `ret_i` low.
- R10: After reset `ie_o`=0, `level_o`=0, `nmi_busy_o`=0 and `take_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary: events are taken here |
| pend_i | input | 3 | Pending bits: [2] external, [1] software, [0] timer |
| mask_i | input | 3 | Per-class enable, same bit order |
| nmi_i | input | 1 | Non-maskable interrupt request |
| exc_req_i | input | 1 | Synchronous exception from the current instruction |
| exc_code_i | input | 4 | Exception cause code |
| thresh_i | input | 2 | Software priority threshold |
| ie_set_i | input | 1 | Set global enable |
| ie_clr_i | input | 1 | Clear global enable |
| ret_i | input | 1 | Return from handler |
| take_o | output | 1 | Take-trap strobe |
| is_irq_o | output | 1 | 1 = interrupt, 0 = exception |
| cause_o | output | 4 | Cause code |
| ie_o | output | 1 | Global interrupt enable |
| level_o | output | 2 | Priority level of the running handler |
| nmi_busy_o | output | 1 | Non-maskable handler active |

## Verification
`take_o`, `is_irq_o` and `cause_o` are combinational, so they are due in the same cycle as the boundary. The bench drives its inputs on the falling edge and samples these outputs 2 ns later. When a probe must not change state, the boundary is dropped again before the next rising edge. `ie_o`, `level_o` and `nmi_busy_o` change at the rising edge that captures a take, a return or an enable pulse. The bench reads them 1 ns after that edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NCLS = 3;            // timer, software, external
  localparam int LVLW = 2;
  localparam int CW   = 4;
  localparam logic [CW-1:0] CODE_TMR = 4'd7;
  localparam logic [CW-1:0] CODE_SW  = 4'd3;
  localparam logic [CW-1:0] CODE_EXT = 4'd11;
  localparam logic [CW-1:0] CODE_NMI = 4'd15;

  typedef struct packed {
    logic            ie;
    logic [LVLW-1:0] lvl;
  } ctx_t;

  typedef struct packed {
    logic            valid;
    logic            irq;
    logic            nmi;
    logic            maskable;
    logic [CW-1:0]   code;
    logic [LVLW-1:0] lvl;
  } pick_t;
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
(
  input  logic [NCLS-1:0] pend_i,
  input  logic [NCLS-1:0] mask_i,
  input  logic            ie_i,
  input  logic [LVLW-1:0] level_i,
  input  logic [LVLW-1:0] thresh_i,
  input  logic            nmi_ok_i,
  input  logic            exc_req_i,
  input  logic [CW-1:0]   exc_code_i,
  output pick_t           pick_o
);
  logic [NCLS-1:0] elig;

  // class i has priority i+1
  for (genvar i = 0; i < NCLS; i++) begin : g_elig
    localparam logic [LVLW-1:0] PRIO = LVLW'(i + 1);
    assign elig[i] = pend_i[i] & mask_i[i] & ie_i &
                     (PRIO > level_i) & (PRIO > thresh_i);
  end

  always_comb begin
    pick_o = '0;
    if (nmi_ok_i) begin
      pick_o.valid = 1'b1; pick_o.irq = 1'b1; pick_o.nmi = 1'b1;
      pick_o.code  = CODE_NMI;
    end else if (elig[2]) begin
      pick_o.valid = 1'b1; pick_o.irq = 1'b1; pick_o.maskable = 1'b1;
      pick_o.code  = CODE_EXT; pick_o.lvl = 2'd3;
    end else if (elig[1]) begin
      pick_o.valid = 1'b1; pick_o.irq = 1'b1; pick_o.maskable = 1'b1;
      pick_o.code  = CODE_SW;  pick_o.lvl = 2'd2;
    end else if (elig[0]) begin
      pick_o.valid = 1'b1; pick_o.irq = 1'b1; pick_o.maskable = 1'b1;
      pick_o.code  = CODE_TMR; pick_o.lvl = 2'd1;
    end else if (exc_req_i) begin
      pick_o.valid = 1'b1;
      pick_o.code  = exc_code_i;
    end
  end
endmodule

// File: rtl/trap_ctx_stack.sv
module trap_ctx_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] up_val, dn_val;
    if (i == 0) begin : g_first
      assign dn_val = din_i;
    end else begin : g_rest
      assign dn_val = mem[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign up_val = '0;
    end else begin : g_mid
      assign up_val = mem[i+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mem[i] <= '0;
      else if (push_i) mem[i] <= dn_val;
      else if (pop_i)  mem[i] <= up_val;
    end
  end

  assign top_o = mem[0];
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int STACK_DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            boundary_i,
  input  logic [NCLS-1:0] pend_i,
  input  logic [NCLS-1:0] mask_i,
  input  logic            nmi_i,
  input  logic            exc_req_i,
  input  logic [CW-1:0]   exc_code_i,
  input  logic [LVLW-1:0] thresh_i,
  input  logic            ie_set_i,
  input  logic            ie_clr_i,
  input  logic            ret_i,
  output logic            take_o,
  output logic            is_irq_o,
  output logic [CW-1:0]   cause_o,
  output logic            ie_o,
  output logic [LVLW-1:0] level_o,
  output logic            nmi_busy_o
);
  localparam int CTXW = $bits(ctx_t);

  logic            ie_q, nmi_q;
  logic [LVLW-1:0] lvl_q;
  pick_t           pick;
  ctx_t            push_ctx, pop_ctx;
  logic            take;

  trap_select u_sel (
    .pend_i    (pend_i),
    .mask_i    (mask_i),
    .ie_i      (ie_q),
    .level_i   (lvl_q),
    .thresh_i  (thresh_i),
    .nmi_ok_i  (nmi_i & ~nmi_q),
    .exc_req_i (exc_req_i),
    .exc_code_i(exc_code_i),
    .pick_o    (pick)
  );

  // a return in the same cycle defers arbitration
  assign take = boundary_i & ~ret_i & pick.valid;

  assign push_ctx.ie  = ie_q;
  assign push_ctx.lvl = lvl_q;

  trap_ctx_stack #(.DEPTH(STACK_DEPTH), .W(CTXW)) u_stk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(take),
    .pop_i (ret_i),
    .din_i (push_ctx),
    .top_o (pop_ctx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      lvl_q <= '0;
      nmi_q <= 1'b0;
    end else if (take) begin
      ie_q <= 1'b0;
      if (pick.maskable) lvl_q <= pick.lvl;
      if (pick.nmi)      nmi_q <= 1'b1;
    end else if (ret_i) begin
      ie_q  <= pop_ctx.ie;
      lvl_q <= pop_ctx.lvl;
      nmi_q <= 1'b0;
    end else if (ie_set_i) begin
      ie_q <= 1'b1;
    end else if (ie_clr_i) begin
      ie_q <= 1'b0;
    end
  end

  assign take_o     = take;
  assign is_irq_o   = take & pick.irq;
  assign cause_o    = take ? pick.code : '0;
  assign ie_o       = ie_q;
  assign level_o    = lvl_q;
  assign nmi_busy_o = nmi_q;
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk
  import trap_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            boundary_i,
  input logic            exc_req_i,
  input logic            ret_i,
  input logic            take_o,
  input logic            is_irq_o,
  input logic [CW-1:0]   cause_o,
  input logic            ie_o,
  input logic [LVLW-1:0] level_o,
  input logic            nmi_busy_o
);
  a_r9_take_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (boundary_i && !ret_i));

  a_r8_take_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !ie_o);

  a_r3_maskable_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && is_irq_o && cause_o != CODE_NMI) |-> ie_o);

  a_r7_nmi_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_busy_o |-> !(take_o && is_irq_o && cause_o == CODE_NMI));

  a_r4_ext_above_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && is_irq_o && cause_o == CODE_EXT) |-> (level_o < 2'd3));

  a_r4_ext_sets_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && is_irq_o && cause_o == CODE_EXT) |=> (level_o == 2'd3));

  a_r1_exc_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !is_irq_o) |-> exc_req_i);
endmodule

bind trap_arbiter trap_arbiter_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .boundary_i(boundary_i),
  .exc_req_i (exc_req_i),
  .ret_i     (ret_i),
  .take_o    (take_o),
  .is_irq_o  (is_irq_o),
  .cause_o   (cause_o),
  .ie_o      (ie_o),
  .level_o   (level_o),
  .nmi_busy_o(nmi_busy_o)
);

// File: tb/trap_arbiter_bench.sv
`timescale 1ns/1ps
module trap_arbiter_bench;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       boundary_i = 0, nmi_i = 0, exc_req_i = 0;
  logic [2:0] pend_i = 0, mask_i = 3'b111;
  logic [3:0] exc_code_i = 0;
  logic [1:0] thresh_i = 0;
  logic       ie_set_i = 0, ie_clr_i = 0, ret_i = 0;
  logic       take_o, is_irq_o, ie_o, nmi_busy_o;
  logic [3:0] cause_o;
  logic [1:0] level_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  trap_arbiter u_trap_arbiter (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_in();
    boundary_i = 0; pend_i = 0; nmi_i = 0; exc_req_i = 0; exc_code_i = 0;
    ret_i = 0; ie_set_i = 0; ie_clr_i = 0;
  endtask

  // drive for one boundary; check comb outputs; optionally let the edge act
  task automatic evt(string tag, logic bnd, logic [2:0] p, logic n, logic e,
                     logic [3:0] c, logic r, logic commit,
                     logic et, logic ei, logic [3:0] ec);
    @(negedge clk_i);
    boundary_i = bnd; pend_i = p; nmi_i = n; exc_req_i = e; exc_code_i = c; ret_i = r;
    #2;
    chk({tag, " take"}, 8'(take_o), 8'(et));
    if (et) begin
      chk({tag, " irq"}, 8'(is_irq_o), 8'(ei));
      chk({tag, " code"}, 8'(cause_o), 8'(ec));
    end
    if (commit) begin
      @(posedge clk_i); #1;
    end
    clr_in();
  endtask

  task automatic pulse(logic s, logic cl, logic r);
    @(negedge clk_i);
    ie_set_i = s; ie_clr_i = cl; ret_i = r;
    @(posedge clk_i); #1;
    clr_in();
  endtask

  task automatic st(string tag, logic ie, logic [1:0] lv, logic nb);
    chk({tag, " ie"}, 8'(ie_o), 8'(ie));
    chk({tag, " level"}, 8'(level_o), 8'(lv));
    chk({tag, " nmi_busy"}, 8'(nmi_busy_o), 8'(nb));
  endtask

  task automatic t_reset();
    chk("R10 take", 8'(take_o), 8'd0);
    st("R10", 0, 0, 0);
  endtask

  task automatic t_enable();
    evt("R3 ie0 timer", 1, 3'b001, 0, 0, 0, 0, 0, 0, 0, 0);
    evt("R3 ie0 exc", 1, 3'b000, 0, 1, 4'd5, 0, 0, 1, 0, 4'd5);
    pulse(1, 0, 0);
    chk("R3 ie_set", 8'(ie_o), 8'd1);
    mask_i = 3'b000;
    evt("R3 masked", 1, 3'b111, 0, 0, 0, 0, 0, 0, 0, 0);
    mask_i = 3'b111;
  endtask

  task automatic t_order();
    evt("R1 all", 1, 3'b111, 0, 1, 4'd9, 0, 0, 1, 1, 4'd11);
    evt("R1 sw", 1, 3'b011, 0, 1, 4'd9, 0, 0, 1, 1, 4'd3);
    evt("R1 tmr", 1, 3'b001, 0, 1, 4'd9, 0, 0, 1, 1, 4'd7);
    evt("R1 exc", 1, 3'b000, 0, 1, 4'd9, 0, 0, 1, 0, 4'd9);
    evt("R1 nmi", 1, 3'b111, 1, 1, 4'd9, 0, 0, 1, 1, 4'd15);
    evt("R9 no boundary", 0, 3'b111, 1, 1, 4'd9, 0, 0, 0, 0, 0);
    evt("R9 during ret", 1, 3'b111, 1, 1, 4'd9, 1, 0, 0, 0, 0);
  endtask

  task automatic t_thresh();
    thresh_i = 2'd1;
    evt("R6 tmr at thr", 1, 3'b001, 0, 0, 0, 0, 0, 0, 0, 0);
    evt("R6 sw above", 1, 3'b010, 0, 0, 0, 0, 0, 1, 1, 4'd3);
    thresh_i = 2'd3;
    evt("R6 ext at thr", 1, 3'b100, 0, 0, 0, 0, 0, 0, 0, 0);
    thresh_i = 2'd2;
    evt("R6 ext above", 1, 3'b100, 0, 0, 0, 0, 0, 1, 1, 4'd11);
    thresh_i = 2'd0;
  endtask

  task automatic t_drop();
    evt("R2 tmr over exc", 1, 3'b001, 0, 1, 4'd6, 0, 1, 1, 1, 4'd7);
    st("R8 after take", 0, 1, 0);
    pulse(0, 0, 1);
    st("R8 after ret", 1, 0, 0);
    evt("R2 exc not kept", 1, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_nest();
    evt("R4 sw", 1, 3'b010, 0, 0, 0, 0, 1, 1, 1, 4'd3);
    pulse(1, 0, 0);
    st("R5 reenabled", 1, 2, 0);
    evt("R4 tmr waits", 1, 3'b001, 0, 0, 0, 0, 0, 0, 0, 0);
    evt("R5 ext preempts", 1, 3'b100, 0, 0, 0, 0, 1, 1, 1, 4'd11);
    st("R5 nested", 0, 3, 0);
    pulse(0, 0, 1);
    st("R8 pop1", 1, 2, 0);
    pulse(0, 0, 1);
    st("R8 pop2", 1, 0, 0);
    evt("R4 tmr now", 1, 3'b001, 0, 0, 0, 0, 0, 1, 1, 4'd7);
  endtask

  task automatic t_depth();
    evt("R8 d1", 1, 3'b001, 0, 0, 0, 0, 1, 1, 1, 4'd7);
    pulse(1, 0, 0);
    evt("R8 d2", 1, 3'b010, 0, 0, 0, 0, 1, 1, 1, 4'd3);
    pulse(1, 0, 0);
    evt("R8 d3", 1, 3'b100, 0, 0, 0, 0, 1, 1, 1, 4'd11);
    pulse(1, 0, 0);
    evt("R8 d4", 1, 3'b000, 0, 1, 4'd4, 0, 1, 1, 0, 4'd4);
    st("R8 deep", 0, 3, 0);
    pulse(0, 0, 1); st("R8 p1", 1, 3, 0);
    pulse(0, 0, 1); st("R8 p2", 1, 2, 0);
    pulse(0, 0, 1); st("R8 p3", 1, 1, 0);
    pulse(0, 0, 1); st("R8 p4", 1, 0, 0);
  endtask

  task automatic t_nmi();
    pulse(0, 1, 0);
    chk("R3 ie_clr", 8'(ie_o), 8'd0);
    evt("R7 nmi ie0", 1, 3'b000, 1, 0, 0, 0, 1, 1, 1, 4'd15);
    st("R7 busy", 0, 0, 1);
    evt("R7 nmi blocked", 1, 3'b000, 1, 0, 0, 0, 0, 0, 0, 0);
    evt("R7 exc in nmi", 1, 3'b000, 1, 1, 4'd2, 0, 1, 1, 0, 4'd2);
    pulse(0, 0, 1);
    chk("R7 released", 8'(nmi_busy_o), 8'd0);
    evt("R7 nmi again", 1, 3'b000, 1, 0, 0, 0, 0, 1, 1, 4'd15);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_enable();
    t_order();
    t_thresh();
    t_drop();
    t_nest();
    t_depth();
    t_nmi();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule